// File: doc/BRIEF.md
# SPI-Refreshed Watchdog Timer

This block is a watchdog that a host keeps alive over a serial link. A frame decoder ahead of it reports each received frame with a one-cycle strobe and the frame's most significant bit, which serves as the keep-alive bit. The host keeps the watchdog alive by flipping that bit from one frame to the next. The bit can flip in any frame type, including a frame that otherwise does nothing. The level of the bit does not matter, and a frame whose bit matches the previous frame does not count as a refresh.

Frames that write the watchdog configuration also carry a 2-bit period code. The four codes select four periods, and they are not in ascending order. A new code does not cut short the count already running. It applies to the next count that starts. Software therefore flips the keep-alive bit in the same write so that the new period starts at once. A 1 ms enable input is the time base. When a full period of ticks goes by with no refresh, a sticky timeout flag rises. The flag stays high until reset.

Top module: `spi_wd_timer`

## Requirements
- R1: After a synchronous active-low reset, `wd_timeout` is 0 and `wd_period_code` is 2'b00. The stored keep-alive reference bit is 0, so the first frame carrying bit 1 counts as a refresh. The count starts from zero using the code-00 period.
- R2: Each code maps to a period in ticks: 2'b00 gives P_CODE0 (558), 2'b01 gives P_CODE1 (279), 2'b10 gives P_CODE2 (2250) and 2'b11 gives P_CODE3 (1125).
- R3: `wd_timeout` rises after exactly the period's number of `tick_ms` pulses since the last restart or reset, provided no restart happens in between. It does not rise after one pulse fewer.
- R4: A frame strobe whose `frame_wd_bit` differs from the bit of the previous frame restarts the count. If no frame has arrived since reset, the comparison is against 0. This holds for frames with and without `cfg_wr`.
- R5: A frame strobe whose `frame_wd_bit` equals the previous frame's bit does not restart the count.
- R6: When `frame_valid` and `cfg_wr` are high together, `cfg_code[1:0]` is loaded into `wd_period_code` at that clock edge. `cfg_wr` without `frame_valid` has no effect.
- R7: A count uses the period that is in effect when the count starts. A code written in a frame that also restarts the count sets the length of that new count. A code written without a restart takes effect only at the next restart.
- R8: Once `wd_timeout` is high, it stays high until reset. Later restarts do not clear it.
- R9: If a restart and a `tick_ms` pulse fall in the same cycle, the restart wins. That tick is not counted, and the timeout cannot rise in that cycle.
- R10: Clock cycles with `tick_ms` low do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-cycle time-base enable, nominally every 1 ms |
| frame_valid | input | 1 | One-cycle strobe for each received frame |
| frame_wd_bit | input | 1 | Keep-alive bit (frame bit 15) of the strobed frame |
| cfg_wr | input | 1 | Strobed frame is a watchdog configuration write |
| cfg_code | input | 2 | Period code from bits 1:0 of the configuration write |
| wd_timeout | output | 1 | Sticky timeout flag |
| wd_period_code | output | 2 | Currently programmed period code |

## Verification
Two events can land in the same cycle: the restart caused by a flipped keep-alive bit, and the expiring tick. The bench provokes this by letting the count run to one tick short of the period, then driving a flipped frame with `tick_ms` high in that same cycle. It checks that the flag stays low and that a full new period is then needed before the flag rises. It also combines a configuration write with a restart in a single frame, and checks that the new code sets the length of the count that frame starts.

// File: rtl/spi_wd_pkg.sv
// Package: shared types and constants for the serial-refreshed watchdog.
// Assumes: period codes are two bits wide and the reset code is 00.
package spi_wd_pkg;
    typedef logic [1:0] wd_code_t;

    localparam wd_code_t WD_CODE_RESET = 2'b00;

    // Largest of four periods, used to size the tick counter.
    function automatic int unsigned wd_max4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction
endpackage

// File: rtl/wd_period_sel.sv
// Module: maps a period code to a tick count.
// Assumes: every period is at least 1 and fits in CNT_W bits.
module wd_period_sel
    import spi_wd_pkg::*;
#(
    parameter int unsigned P_CODE0 = 558,
    parameter int unsigned P_CODE1 = 279,
    parameter int unsigned P_CODE2 = 2250,
    parameter int unsigned P_CODE3 = 1125,
    parameter int unsigned CNT_W   = 12
) (
    input  wd_code_t          code,
    output logic [CNT_W-1:0]  limit
);
    // Code-to-period lookup; the order is not monotonic on purpose.
    always_comb begin
        unique case (code)
            2'b00:   limit = CNT_W'(P_CODE0);
            2'b01:   limit = CNT_W'(P_CODE1);
            2'b10:   limit = CNT_W'(P_CODE2);
            default: limit = CNT_W'(P_CODE3);
        endcase
    end
endmodule

// File: rtl/wd_toggle_det.sv
// Module: remembers the keep-alive bit of the last frame and flags a change.
// Assumes: frame_valid is a single-cycle strobe; the reset reference is 0.
module wd_toggle_det (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_valid,
    input  logic frame_wd_bit,
    output logic restart
);
    logic wd_bit_q;

    // A restart is any frame whose bit differs from the stored one.
    assign restart = frame_valid && (frame_wd_bit != wd_bit_q);

    // Store the bit of every frame, whether or not it changed.
    always_ff @(posedge clk) begin
        if (!rst_n)           wd_bit_q <= 1'b0;
        else if (frame_valid) wd_bit_q <= frame_wd_bit;
    end
endmodule

// File: rtl/wd_cfg_reg.sv
// Module: holds the programmed period code and gives the code a restart would use.
// Assumes: a configuration write is valid only together with a frame strobe.
module wd_cfg_reg
    import spi_wd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     frame_valid,
    input  logic     cfg_wr,
    input  wd_code_t cfg_code,
    output wd_code_t code_q,
    output wd_code_t code_next
);
    logic load;

    assign load      = frame_valid && cfg_wr;
    // The same-frame code wins, so a write plus a flip starts the new period.
    assign code_next = load ? cfg_code : code_q;

    // Programmed code register.
    always_ff @(posedge clk) begin
        if (!rst_n)    code_q <= WD_CODE_RESET;
        else if (load) code_q <= cfg_code;
    end
endmodule

// File: rtl/wd_tick_counter.sv
// Module: counts time-base ticks against a period latched at each restart
//         and raises a sticky expiry flag.
// Assumes: RESET_LIMIT equals the period of the reset code; limits are >= 1.
module wd_tick_counter #(
    parameter int unsigned CNT_W       = 12,
    parameter int unsigned RESET_LIMIT = 558
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit_in,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit_q;
    logic             last_tick;

    // The tick that brings the count to the period ends it.
    assign last_tick = tick && !expired && (cnt_q == limit_q - CNT_W'(1));

    // Count and period latch; a restart takes priority over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            limit_q <= CNT_W'(RESET_LIMIT);
        end else if (restart) begin
            cnt_q   <= '0;
            limit_q <= limit_in;
        end else if (tick && !expired && !last_tick) begin
            cnt_q   <= cnt_q + CNT_W'(1);
        end
    end

    // Sticky expiry flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                    expired <= 1'b0;
        else if (last_tick && !restart) expired <= 1'b1;
    end
endmodule

// File: rtl/spi_wd_timer.sv
// Module: top of the serial-refreshed watchdog. It ties the toggle detector,
//         the code register, the period lookup and the tick counter together.
// Assumes: frame strobes come from an upstream decoder; tick_ms is a one-cycle
//          enable; synchronous active-low reset.
module spi_wd_timer
    import spi_wd_pkg::*;
#(
    parameter int unsigned P_CODE0 = 558,
    parameter int unsigned P_CODE1 = 279,
    parameter int unsigned P_CODE2 = 2250,
    parameter int unsigned P_CODE3 = 1125
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       frame_valid,
    input  logic       frame_wd_bit,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_code,
    output logic       wd_timeout,
    output logic [1:0] wd_period_code
);
    localparam int unsigned P_MAX = wd_max4(P_CODE0, P_CODE1, P_CODE2, P_CODE3);
    localparam int unsigned CNT_W = $clog2(P_MAX + 1);

    logic             restart;
    wd_code_t         code_q;
    wd_code_t         code_next;
    logic [CNT_W-1:0] limit_next;

    wd_toggle_det u_toggle (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_valid  (frame_valid),
        .frame_wd_bit (frame_wd_bit),
        .restart      (restart)
    );

    wd_cfg_reg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .cfg_wr      (cfg_wr),
        .cfg_code    (cfg_code),
        .code_q      (code_q),
        .code_next   (code_next)
    );

    wd_period_sel #(
        .P_CODE0 (P_CODE0),
        .P_CODE1 (P_CODE1),
        .P_CODE2 (P_CODE2),
        .P_CODE3 (P_CODE3),
        .CNT_W   (CNT_W)
    ) u_sel (
        .code  (code_next),
        .limit (limit_next)
    );

    wd_tick_counter #(
        .CNT_W       (CNT_W),
        .RESET_LIMIT (P_CODE0)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_ms),
        .restart  (restart),
        .limit_in (limit_next),
        .expired  (wd_timeout)
    );

    assign wd_period_code = code_q;
endmodule

// File: rtl/spi_wd_timer_chk.sv
// Module: property checker for spi_wd_timer, attached through bind.
// Assumes: it sees only the top-level ports and keeps its own copy of the last frame bit.
module spi_wd_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_ms,
    input logic       frame_valid,
    input logic       frame_wd_bit,
    input logic       cfg_wr,
    input logic [1:0] cfg_code,
    input logic       wd_timeout,
    input logic [1:0] wd_period_code
);
    logic shadow_bit;

    // Independent copy of the previous frame's keep-alive bit.
    always_ff @(posedge clk) begin
        if (!rst_n)           shadow_bit <= 1'b0;
        else if (frame_valid) shadow_bit <= frame_wd_bit;
    end

    AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wd_timeout |=> wd_timeout); // R8
    AST_CODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && cfg_wr) |=> (wd_period_code == $past(cfg_code))); // R6
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_valid && cfg_wr) |=> $stable(wd_period_code)); // R6
    AST_NO_TICK_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_ms |=> !$rose(wd_timeout)); // R10
    AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && (frame_wd_bit != shadow_bit)) |=> !$rose(wd_timeout)); // R9
endmodule

bind spi_wd_timer spi_wd_timer_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick_ms        (tick_ms),
    .frame_valid    (frame_valid),
    .frame_wd_bit   (frame_wd_bit),
    .cfg_wr         (cfg_wr),
    .cfg_code       (cfg_code),
    .wd_timeout     (wd_timeout),
    .wd_period_code (wd_period_code)
);

// File: tb/spi_wd_timer_tb.sv
// Bench: small periods so every code can be swept in full; expected values computed here.
module spi_wd_timer_tb;
    localparam int unsigned TP0 = 5;
    localparam int unsigned TP1 = 3;
    localparam int unsigned TP2 = 11;
    localparam int unsigned TP3 = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       frame_valid = 1'b0;
    logic       frame_wd_bit = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_code = 2'b00;
    logic       wd_timeout;
    logic [1:0] wd_period_code;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    spi_wd_timer #(
        .P_CODE0 (TP0), .P_CODE1 (TP1), .P_CODE2 (TP2), .P_CODE3 (TP3)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .tick_ms (tick_ms),
        .frame_valid (frame_valid), .frame_wd_bit (frame_wd_bit),
        .cfg_wr (cfg_wr), .cfg_code (cfg_code),
        .wd_timeout (wd_timeout), .wd_period_code (wd_period_code)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run is a failure and still reaches the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic int unsigned exp_period(input logic [1:0] c);
        case (c)
            2'b00:   return TP0;
            2'b01:   return TP1;
            2'b10:   return TP2;
            default: return TP3;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // n tick pulses, each followed by a cycle with the tick low.
    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_ms = 1'b1;
            @(negedge clk); tick_ms = 1'b0;
        end
    endtask

    // One frame strobe; optionally a tick in the same cycle.
    task automatic frame(input logic b, input logic wr, input logic [1:0] c, input logic with_tick);
        @(negedge clk);
        frame_valid = 1'b1; frame_wd_bit = b; cfg_wr = wr; cfg_code = c; tick_ms = with_tick;
        @(negedge clk);
        frame_valid = 1'b0; cfg_wr = 1'b0; tick_ms = 1'b0;
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        check("R1 timeout after reset", wd_timeout, 0);
        check("R1 code after reset", wd_period_code, 0);

        // R3/R1: count from reset with code 00.
        tick_n(TP0 - 1);
        check("R3 no expiry one tick short", wd_timeout, 0);
        tick_n(1);
        check("R3 expiry at period", wd_timeout, 1);

        // R10: idle cycles do not count.
        do_reset();
        repeat (40) @(negedge clk);
        check("R10 no ticks no expiry", wd_timeout, 0);

        // R2/R7: each code, written together with a flip, sets the period.
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < int'(TP0); k++) begin
                do_reset();
                tick_n(k);
                frame(1'b1, 1'b1, 2'(c), 1'b0);
                check("R6 code loaded", wd_period_code, c);
                tick_n(exp_period(2'(c)) - 1);
                check("R2 R7 before period", wd_timeout, 0);
                tick_n(1);
                check("R2 R7 at period", wd_timeout, 1);
            end
        end

        // R7: write without a flip keeps the running period; the next flip uses it.
        do_reset();
        frame(1'b0, 1'b1, 2'b10, 1'b0);
        check("R6 code 10 loaded", wd_period_code, 2);
        tick_n(TP0);
        check("R7 old period still runs", wd_timeout, 1);
        do_reset();
        frame(1'b0, 1'b1, 2'b10, 1'b0);
        tick_n(3);
        frame(1'b1, 1'b0, 2'b00, 1'b0);
        tick_n(TP2 - 1);
        check("R7 new period on next restart before", wd_timeout, 0);
        tick_n(1);
        check("R7 new period on next restart at", wd_timeout, 1);

        // R6: cfg_wr without a frame strobe is ignored.
        do_reset();
        @(negedge clk); cfg_wr = 1'b1; cfg_code = 2'b11;
        @(negedge clk); cfg_wr = 1'b0;
        @(negedge clk);
        check("R6 cfg_wr alone ignored", wd_period_code, 0);

        // R5: same-level frame does not restart.
        do_reset();
        tick_n(3);
        frame(1'b0, 1'b0, 2'b00, 1'b0);
        tick_n(TP0 - 3);
        check("R5 equal bit no restart", wd_timeout, 1);

        // R4: flips in both directions on no-op frames restart.
        do_reset();
        tick_n(TP0 - 1);
        frame(1'b1, 1'b0, 2'b00, 1'b0);
        tick_n(TP0 - 1);
        frame(1'b0, 1'b0, 2'b00, 1'b0);
        tick_n(TP0 - 1);
        check("R4 flips keep alive", wd_timeout, 0);
        tick_n(1);
        check("R4 expiry after last flip", wd_timeout, 1);

        // R8: sticky through later flips.
        frame(1'b1, 1'b0, 2'b00, 1'b0);
        repeat (3) @(negedge clk);
        check("R8 timeout stays high", wd_timeout, 1);

        // R9: flip on the expiring tick wins.
        do_reset();
        tick_n(TP0 - 1);
        frame(1'b1, 1'b0, 2'b00, 1'b1);
        check("R9 same-cycle restart wins", wd_timeout, 0);
        tick_n(TP0 - 1);
        check("R9 full period after restart", wd_timeout, 0);
        tick_n(1);
        check("R9 expiry after full period", wd_timeout, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule